// File: doc/BRIEF.md
# Protection information tuple checker

This block verifies the per-block protection tuples of a storage transfer. A command is loaded with a single start pulse. The command carries the guard format (a 16-bit or a 64-bit guard), the protection type, three check-enable bits, an expected application tag with its mask, a 64-bit starting reference tag supplied as two 32-bit words, the starting logical block address and the block count. The block first decides whether the protection settings of the command are acceptable. It answers with a single response pulse, and only an accepted command opens the byte stream.

Each block then arrives as a valid/ready byte stream. The stream holds every guarded byte (the user data followed by any metadata bytes ahead of the tuple), and the last beat is flagged. The stored tuple (guard, application tag, reference tag) travels as sideband on that last beat. The block recomputes the guard CRC, applies the all-ones escape rules, and compares the enabled fields in a fixed precedence. It reports a 2-bit status per block. The transfer ends at the first failing block or after the final block, and the index of that block is reported. Back-pressure: `s_ready` is high only while a transfer is open. A byte is consumed only on a cycle where both `s_valid` and `s_ready` are high. The source may hold `s_valid` low for any number of cycles without effect. After the transfer ends, `s_ready` is low until the next accepted command.

Top module: `pi_tuple_checker`

## Requirements
- R1: With protection type 1 (type code 2'd1) and the reference check enabled, the command is rejected with `cmd_rej=1` and `cmd_dnr=1` unless the starting address masked to 32 bits (16-bit guard format) or 48 bits (64-bit format) equals the full 64-bit expected reference tag. A rejected command opens no stream.
- R2: With protection type 3 (type code 2'd3) and the reference check enabled, every command is rejected with `cmd_rej=1` and `cmd_dnr=0`.
- R3: `cmd_resp` pulses for one cycle on the second clock edge after the edge that samples `cmd_start` in idle. An accepted command raises `s_ready` from that same edge.
- R4: The guard is a CRC computed over all streamed bytes of a block. In the 16-bit format it uses polynomial 0x8BB7, initial value 0, MSB first, no final inversion. In the 64-bit format it is bit-reflected with polynomial 0x9A6C9329AC4BC9B5, and both the initial value and the final XOR are all ones. With the guard check enabled, a mismatch gives status 2'b01.
- R5: With the application tag check enabled, the status is 2'b10 when (stored tag & mask) differs from (expected tag & mask). Bits outside the mask never cause this error.
- R6: With the reference check enabled, the status is 2'b11 when the stored reference tag differs from the expected one. The stored tag is 32 bits wide in the 16-bit format and 48 bits wide in the 64-bit format, and it is zero-extended before the comparison.
- R7: When several enabled checks fail, guard outranks application tag, which outranks reference tag. A disabled check never produces an error. Status 2'b00 means success.
- R8: For type codes 1 and 2, a stored application tag of 0xFFFF makes the block pass with status 2'b00 whatever its other fields are.
- R9: For type 3, a block is exempt only when the stored application tag is 0xFFFF and the stored reference tag is all ones (32 bits in the 16-bit format, 48 bits in the 64-bit format). Either condition alone does not exempt it.
- R10: The expected reference tag starts as {high word, low word} and advances by one after each passing block, except under type 3, where it stays fixed.
- R11: `blk_done` pulses after each block's last beat with that block's status. `xfer_done` pulses together with the first failing block's `blk_done`, or with the last block's. It carries the status in `xfer_status` and the block index in `fail_idx`, after which `s_ready` is low.
- R12: Command fields are sampled only on `cmd_start` in idle. Changing them during a transfer has no effect on the results.
- R13: Idle cycles with `s_valid` low do not change the guard or the block position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse, sampled in idle |
| cmd_fmt64 | input | 1 | 1 selects the 64-bit guard format |
| cmd_ptype | input | 2 | Protection type code 0..3 |
| cmd_chk_guard | input | 1 | Enable guard comparison |
| cmd_chk_app | input | 1 | Enable application tag comparison |
| cmd_chk_ref | input | 1 | Enable reference tag comparison |
| cmd_app_tag | input | 16 | Expected application tag |
| cmd_app_mask | input | 16 | Application tag compare mask |
| cmd_ref_lo | input | 32 | Expected reference tag, low word |
| cmd_ref_hi | input | 32 | Expected reference tag, high word |
| cmd_slba | input | 64 | Starting logical block address |
| cmd_nblk_m1 | input | CNT_W | Number of blocks minus one |
| cmd_resp | output | 1 | Command validation response pulse |
| cmd_rej | output | 1 | Command rejected (valid with cmd_resp) |
| cmd_dnr | output | 1 | Rejection is not retryable |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last guarded byte of the block |
| s_guard | input | 64 | Stored guard (low 16 bits in 16-bit format), with s_last |
| s_app | input | 16 | Stored application tag, with s_last |
| s_ref | input | 48 | Stored reference tag (low 32 bits in 16-bit format), with s_last |
| blk_done | output | 1 | Per-block result pulse |
| blk_status | output | 2 | Per-block status: 00 ok, 01 guard, 10 app, 11 ref |
| xfer_done | output | 1 | Transfer finished pulse |
| xfer_status | output | 2 | Final transfer status |
| fail_idx | output | CNT_W | Index of the block that ended the transfer |

## Verification
Some situations are hard to reach from the ports. One is a late block failing its reference check while earlier blocks pass and keep advancing the expected tag. Another is a type 3 block where only one of the two all-ones escape fields is present. A third is a 64-bit command whose high reference word matters. The bench builds multi-block commands with a chosen tag per block, and it corrupts one block in the middle. It also sweeps every format, type, enable set and corruption pattern for single blocks. The escape cases are hand-placed with corrupted guards, so that a wrong escape decision shows up as a guard error.

// File: rtl/pi_pkg.sv
package pi_pkg;

  localparam logic [1:0] PT_NONE = 2'd0;
  localparam logic [1:0] PT_T1   = 2'd1;
  localparam logic [1:0] PT_T2   = 2'd2;
  localparam logic [1:0] PT_T3   = 2'd3;

  localparam logic [15:0] POLY16 = 16'h8BB7;
  localparam logic [63:0] POLY64 = 64'h9A6C9329AC4BC9B5;

  typedef enum logic [1:0] {
    PI_OK        = 2'b00,
    PI_GUARD_ERR = 2'b01,
    PI_APP_ERR   = 2'b10,
    PI_REF_ERR   = 2'b11
  } pi_status_t;

  typedef struct packed {
    logic chk_ref;
    logic chk_app;
    logic chk_guard;
  } pi_enables_t;

  function automatic logic [63:0] crc_seed(input logic wide);
    return wide ? '1 : '0;
  endfunction

  function automatic logic [63:0] crc_byte(input logic [63:0] c, input logic [7:0] b,
                                           input logic wide);
    logic [63:0] r;
    logic [15:0] n;
    r = c;
    if (wide) begin
      r[7:0] = r[7:0] ^ b;
      for (int k = 0; k < 8; k++) begin
        r = r[0] ? ((r >> 1) ^ POLY64) : (r >> 1);
      end
    end else begin
      n = r[15:0];
      n[15:8] = n[15:8] ^ b;
      for (int k = 0; k < 8; k++) begin
        n = n[15] ? ({n[14:0], 1'b0} ^ POLY16) : {n[14:0], 1'b0};
      end
      r = {48'b0, n};
    end
    return r;
  endfunction

endpackage

// File: rtl/pi_crc_engine.sv
module pi_crc_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [63:0] guard
);
  import pi_pkg::*;

  logic [63:0] acc, acc_nxt;

  always_comb begin
    acc_nxt = en ? crc_byte(acc, din, wide) : acc;
    guard   = wide ? ~acc_nxt : {48'b0, acc_nxt[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= crc_seed(wide);
    else if (en)    acc <= acc_nxt;
  end

  // R13: the running guard holds on cycles without a consumed byte
  p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(acc));

endmodule

// File: rtl/pi_cmd_validate.sv
module pi_cmd_validate (
  input  logic        fmt64,
  input  logic [1:0]  ptype,
  input  logic        chk_ref,
  input  logic [63:0] slba,
  input  logic [63:0] ref_tag,
  output logic        reject,
  output logic        dnr
);
  import pi_pkg::*;

  logic [63:0] addr_mask;
  logic        t1_bad, t3_bad;

  always_comb begin
    addr_mask = fmt64 ? 64'h0000_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    t1_bad    = (ptype == PT_T1) && chk_ref && ((slba & addr_mask) != ref_tag);
    t3_bad    = (ptype == PT_T3) && chk_ref;
    reject    = t1_bad || t3_bad;
    dnr       = t1_bad;
  end

endmodule

// File: rtl/pi_tuple_compare.sv
module pi_tuple_compare (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        fmt64,
  input  logic [1:0]  ptype,
  input  logic [2:0]  enables,
  input  logic [63:0] calc_guard,
  input  logic [63:0] tup_guard,
  input  logic [15:0] tup_app,
  input  logic [47:0] tup_ref,
  input  logic [15:0] exp_app,
  input  logic [15:0] app_mask,
  input  logic [63:0] exp_ref,
  output logic [1:0]  status
);
  import pi_pkg::*;

  pi_enables_t en;
  logic        app_ones, ref_ones, exempt;
  logic        guard_bad, app_bad, ref_bad;
  logic [63:0] stored_guard, stored_ref;
  pi_status_t  res;

  always_comb begin
    en           = pi_enables_t'(enables);
    stored_guard = fmt64 ? tup_guard : {48'b0, tup_guard[15:0]};
    stored_ref   = fmt64 ? {16'b0, tup_ref} : {32'b0, tup_ref[31:0]};
    app_ones     = (tup_app == 16'hFFFF);
    ref_ones     = fmt64 ? (&tup_ref) : (&tup_ref[31:0]);
    case (ptype)
      PT_T1, PT_T2: exempt = app_ones;
      PT_T3:        exempt = app_ones && ref_ones;
      default:      exempt = 1'b0;
    endcase
    guard_bad = en.chk_guard && (stored_guard != calc_guard);
    app_bad   = en.chk_app && ((tup_app & app_mask) != (exp_app & app_mask));
    ref_bad   = en.chk_ref && (stored_ref != exp_ref);
    if (exempt)         res = PI_OK;
    else if (guard_bad) res = PI_GUARD_ERR;
    else if (app_bad)   res = PI_APP_ERR;
    else if (ref_bad)   res = PI_REF_ERR;
    else                res = PI_OK;
    status = res;
  end

  // R7: a lower-ranked error is never reported while the guard check fails
  p_rank_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (res == PI_APP_ERR || res == PI_REF_ERR)) |-> !guard_bad);

  // R7: a reference error implies the application tag compare was clean
  p_rank_app_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && res == PI_REF_ERR) |-> !app_bad);

  // R8: types 1/2 with all-ones application tag always pass
  p_escape12_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (ptype == PT_T1 || ptype == PT_T2) && app_ones) |-> (res == PI_OK));

endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_fmt64,
  input  logic [1:0]       cmd_ptype,
  input  logic             cmd_chk_guard,
  input  logic             cmd_chk_app,
  input  logic             cmd_chk_ref,
  input  logic [15:0]      cmd_app_tag,
  input  logic [15:0]      cmd_app_mask,
  input  logic [31:0]      cmd_ref_lo,
  input  logic [31:0]      cmd_ref_hi,
  input  logic [63:0]      cmd_slba,
  input  logic [CNT_W-1:0] cmd_nblk_m1,
  output logic             cmd_resp,
  output logic             cmd_rej,
  output logic             cmd_dnr,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  input  logic [63:0]      s_guard,
  input  logic [15:0]      s_app,
  input  logic [47:0]      s_ref,
  output logic             blk_done,
  output logic [1:0]       blk_status,
  output logic             xfer_done,
  output logic [1:0]       xfer_status,
  output logic [CNT_W-1:0] fail_idx
);
  import pi_pkg::*;

  localparam logic [CNT_W-1:0] IDX_ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_VALID, S_RUN} fsm_t;

  fsm_t             st;
  logic             l_fmt64;
  logic [1:0]       l_ptype;
  logic [2:0]       l_en;
  logic [15:0]      l_app, l_mask;
  logic [63:0]      l_slba, ref_exp;
  logic [CNT_W-1:0] l_nm1, idx;

  logic             beat, blk_end, crc_clr;
  logic             v_rej, v_dnr;
  logic [63:0]      calc_guard;
  logic [1:0]       status_now;

  assign s_ready = (st == S_RUN);
  assign beat    = s_valid && s_ready;
  assign blk_end = beat && s_last;
  assign crc_clr = (st == S_VALID) || blk_end;

  pi_cmd_validate u_val (
    .fmt64   (l_fmt64),
    .ptype   (l_ptype),
    .chk_ref (l_en[2]),
    .slba    (l_slba),
    .ref_tag (ref_exp),
    .reject  (v_rej),
    .dnr     (v_dnr)
  );

  pi_crc_engine u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .wide  (l_fmt64),
    .clear (crc_clr),
    .en    (beat),
    .din   (s_data),
    .guard (calc_guard)
  );

  pi_tuple_compare u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (blk_end),
    .fmt64      (l_fmt64),
    .ptype      (l_ptype),
    .enables    (l_en),
    .calc_guard (calc_guard),
    .tup_guard  (s_guard),
    .tup_app    (s_app),
    .tup_ref    (s_ref),
    .exp_app    (l_app),
    .app_mask   (l_mask),
    .exp_ref    (ref_exp),
    .status     (status_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      l_fmt64     <= 1'b0;
      l_ptype     <= PT_NONE;
      l_en        <= '0;
      l_app       <= '0;
      l_mask      <= '0;
      l_slba      <= '0;
      l_nm1       <= '0;
      ref_exp     <= '0;
      idx         <= '0;
      cmd_resp    <= 1'b0;
      cmd_rej     <= 1'b0;
      cmd_dnr     <= 1'b0;
      blk_done    <= 1'b0;
      blk_status  <= PI_OK;
      xfer_done   <= 1'b0;
      xfer_status <= PI_OK;
      fail_idx    <= '0;
    end else begin
      cmd_resp  <= 1'b0;
      blk_done  <= 1'b0;
      xfer_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_start) begin
            l_fmt64 <= cmd_fmt64;
            l_ptype <= cmd_ptype;
            l_en    <= {cmd_chk_ref, cmd_chk_app, cmd_chk_guard};
            l_app   <= cmd_app_tag;
            l_mask  <= cmd_app_mask;
            l_slba  <= cmd_slba;
            l_nm1   <= cmd_nblk_m1;
            ref_exp <= {cmd_ref_hi, cmd_ref_lo};
            st      <= S_VALID;
          end
        end
        S_VALID: begin
          cmd_resp <= 1'b1;
          cmd_rej  <= v_rej;
          cmd_dnr  <= v_dnr;
          idx      <= '0;
          st       <= v_rej ? S_IDLE : S_RUN;
        end
        S_RUN: begin
          if (blk_end) begin
            blk_done   <= 1'b1;
            blk_status <= status_now;
            if (status_now != PI_OK || idx == l_nm1) begin
              xfer_done   <= 1'b1;
              xfer_status <= status_now;
              fail_idx    <= idx;
              st          <= S_IDLE;
            end else begin
              idx <= idx + IDX_ONE;
              if (l_ptype != PT_T3) ref_exp <= ref_exp + 64'd1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: response exactly two edges after the start is taken
  p_resp_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_start) |=> ##1 cmd_resp);

  // R1: a non-retryable flag only comes with a rejection
  p_dnr_with_rej_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_resp && cmd_dnr) |-> cmd_rej);

  // R11: a failing block closes the transfer
  p_fail_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && blk_status != PI_OK) |-> xfer_done);

  // R11: end of transfer only on a block result, and the stream is closed
  p_end_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (blk_done && !s_ready));

  // R10: under type 3 the expected reference tag never moves during a transfer
  p_t3_ref_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && l_ptype == PT_T3) |=> $stable(ref_exp));

  // R13: a stalled stream leaves the block position unchanged
  p_stall_idx_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !s_valid) |=> $stable(idx));

endmodule

// File: tb/sim_pi_tuple_checker.sv
module sim_pi_tuple_checker;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             cmd_start = 0, cmd_fmt64 = 0, cmd_chk_guard = 0, cmd_chk_app = 0, cmd_chk_ref = 0;
  logic [1:0]       cmd_ptype = 0;
  logic [15:0]      cmd_app_tag = 0, cmd_app_mask = 0;
  logic [31:0]      cmd_ref_lo = 0, cmd_ref_hi = 0;
  logic [63:0]      cmd_slba = 0;
  logic [CNT_W-1:0] cmd_nblk_m1 = 0;
  logic             cmd_resp, cmd_rej, cmd_dnr;
  logic             s_valid = 0, s_last = 0, s_ready;
  logic [7:0]       s_data = 0;
  logic [63:0]      s_guard = 0;
  logic [15:0]      s_app = 0;
  logic [47:0]      s_ref = 0;
  logic             blk_done, xfer_done;
  logic [1:0]       blk_status, xfer_status;
  logic [CNT_W-1:0] fail_idx;

  pi_tuple_checker #(.CNT_W(CNT_W)) u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] blk_data [0:15];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_crc(input bit wide, input int len);
    logic [63:0] c;
    logic fb;
    c = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
    for (int i = 0; i < len; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (wide) begin
          fb = c[0] ^ blk_data[i][k];
          c = c >> 1;
          if (fb) c = c ^ 64'h9A6C9329AC4BC9B5;
        end else begin
          fb = c[15] ^ blk_data[i][7-k];
          c = {48'b0, c[14:0], 1'b0};
          if (fb) c = c ^ 64'h8BB7;
        end
      end
    end
    return wide ? ~c : c;
  endfunction

  task automatic do_cmd(input bit fmt, input logic [1:0] pt, input logic [2:0] en,
                        input logic [15:0] app, input logic [15:0] mask, input logic [63:0] rf,
                        input logic [63:0] slba, input int nm1,
                        output logic rej, output logic dnr);
    @(negedge clk);
    cmd_start = 1; cmd_fmt64 = fmt; cmd_ptype = pt;
    {cmd_chk_ref, cmd_chk_app, cmd_chk_guard} = en;
    cmd_app_tag = app; cmd_app_mask = mask;
    {cmd_ref_hi, cmd_ref_lo} = rf; cmd_slba = slba; cmd_nblk_m1 = CNT_W'(nm1);
    @(negedge clk);
    cmd_start = 0;
    chk(!cmd_resp, "R3 no early response", 64'(cmd_resp), 0);
    @(negedge clk);
    chk(cmd_resp, "R3 response pulse", 64'(cmd_resp), 1);
    chk(s_ready == !cmd_rej, "R3 ready after accept", 64'(s_ready), 64'(!cmd_rej));
    rej = cmd_rej; dnr = cmd_dnr;
  endtask

  task automatic send_block(input int len, input logic [63:0] g, input logic [15:0] app,
                            input logic [47:0] rf, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps) begin
        s_valid = 0; s_data = 8'hA5; s_last = 1;
        @(negedge clk);
      end
      s_valid = 1; s_data = blk_data[i]; s_last = (i == len - 1);
      s_guard = g; s_app = app; s_ref = rf;
      @(negedge clk);
    end
    s_valid = 0; s_last = 0;
  endtask

  task automatic fill(input int seed, input int len);
    for (int i = 0; i < len; i++) blk_data[i] = 8'((i * 37) ^ (seed * 11) ^ 8'h5C);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic rej, dnr;
    logic [63:0] g, rf;
    logic [1:0] expst;
    repeat (3) @(negedge clk);
    chk(!cmd_resp && !blk_done && !xfer_done && !s_ready, "R3 reset state",
        {cmd_resp, blk_done, xfer_done, s_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    s_valid = 1;
    @(negedge clk);
    chk(!s_ready, "R11 idle not ready", 64'(s_ready), 0);
    s_valid = 0;

    // R4 known vectors: "123456789"
    for (int i = 0; i < 9; i++) blk_data[i] = 8'h31 + 8'(i);
    do_cmd(0, 2'd2, 3'b001, 0, 0, 0, 0, 0, rej, dnr);
    send_block(9, 64'hD0DB, 16'h0, 48'h0, 0);
    chk(blk_done && blk_status == 2'b00, "R4 crc16 vector", 64'(blk_status), 0);
    do_cmd(1, 2'd2, 3'b001, 0, 0, 0, 0, 0, rej, dnr);
    send_block(9, 64'hAE8B14860A799888, 16'h0, 48'h0, 1);
    chk(blk_done && blk_status == 2'b00, "R4 crc64 vector", 64'(blk_status), 0);

    // R4 R5 R6 R7 sweep: format x type x enables x corruption
    for (int fmt = 0; fmt < 2; fmt++)
      for (int pt = 1; pt < 4; pt++)
        for (int en = 0; en < 8; en++)
          for (int bad = 0; bad < 8; bad++) begin
            rf = 64'h40 + 64'(bad);
            do_cmd(fmt[0], 2'(pt), 3'(en), 16'h1234, 16'hFF0F, rf, rf, 0, rej, dnr);
            if (pt == 3 && en[2]) begin
              chk(rej && !dnr, "R2 type3 ref check rejected", {rej, dnr}, 2'b10);
            end else begin
              fill(fmt + en * 3 + bad * 5, 6);
              g = ref_crc(fmt[0], 6) ^ 64'(bad[0]);
              expst = (en[0] && bad[0]) ? 2'b01 : (en[1] && bad[1]) ? 2'b10 :
                      (en[2] && bad[2]) ? 2'b11 : 2'b00;
              send_block(6, g, 16'h1234 ^ (bad[1] ? 16'h0100 : 16'h0030),
                         rf[47:0] ^ 48'(bad[2]), bad[0]);
              chk(blk_done && xfer_done && blk_status == expst && xfer_status == expst,
                  "R7 sweep status", 64'(blk_status), 64'(expst));
            end
          end

    // R1 command validation
    do_cmd(0, 2'd1, 3'b100, 0, 0, 64'h6, 64'h5, 0, rej, dnr);
    chk(rej && dnr, "R1 type1 mismatch", {rej, dnr}, 2'b11);
    chk(!s_ready, "R1 no stream after reject", 64'(s_ready), 0);
    do_cmd(0, 2'd1, 3'b100, 0, 0, 64'h1_0000_0007, 64'h1_0000_0007, 0, rej, dnr);
    chk(rej && dnr, "R1 32-bit mask rejects wide tag", {rej, dnr}, 2'b11);
    do_cmd(1, 2'd1, 3'b100, 0, 0, 64'h1_0000_0007, 64'h1_0000_0007, 0, rej, dnr);
    chk(!rej, "R1 48-bit mask accepts", 64'(rej), 0);
    fill(1, 4);
    send_block(4, 0, 16'h0, 48'h1_0000_0007, 0);
    chk(blk_status == 2'b00, "R6 48-bit reference", 64'(blk_status), 0);
    do_cmd(0, 2'd1, 3'b011, 0, 0, 64'h6, 64'h5, 0, rej, dnr);
    chk(!rej, "R1 no ref check no reject", 64'(rej), 0);
    fill(2, 3);
    send_block(3, ref_crc(0, 3), 16'h0, 48'h0, 0);

    // R8 R9 escapes (guard corrupted)
    fill(3, 5);
    do_cmd(0, 2'd1, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(0, 5), 16'hFFFF, 48'h0, 0);
    chk(blk_status == 2'b00, "R8 type1 escape", 64'(blk_status), 0);
    do_cmd(1, 2'd2, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(1, 5), 16'hFFFF, 48'h0, 1);
    chk(blk_status == 2'b00, "R8 type2 escape", 64'(blk_status), 0);
    do_cmd(0, 2'd3, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(0, 5), 16'hFFFF, 48'h0, 0);
    chk(blk_status == 2'b01, "R9 type3 app only", 64'(blk_status), 1);
    do_cmd(0, 2'd3, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(0, 5), 16'hFFFF, 48'h0000_FFFF_FFFF, 0);
    chk(blk_status == 2'b00, "R9 type3 both 32-bit", 64'(blk_status), 0);
    do_cmd(1, 2'd3, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(1, 5), 16'hFFFF, 48'h0000_FFFF_FFFF, 0);
    chk(blk_status == 2'b01, "R9 type3 wide needs 48 ones", 64'(blk_status), 1);
    do_cmd(1, 2'd3, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(1, 5), 16'hFFFF, 48'hFFFF_FFFF_FFFF, 0);
    chk(blk_status == 2'b00, "R9 type3 wide escape", 64'(blk_status), 0);
    do_cmd(0, 2'd3, 3'b011, 16'h0, 16'hFFFF, 0, 0, 0, rej, dnr);
    send_block(5, ~ref_crc(0, 5), 16'h1234, 48'h0000_FFFF_FFFF, 0);
    chk(blk_status == 2'b01, "R9 type3 ref only", 64'(blk_status), 1);

    // R10 R11 multi-block with incrementing tag, high word used
    rf = {32'h0000_1234, 32'hFFFF_FFFE};
    do_cmd(1, 2'd2, 3'b101, 0, 0, rf, 0, 3, rej, dnr);
    for (int b = 0; b < 4; b++) begin
      fill(b + 20, 7);
      send_block(7, ref_crc(1, 7), 16'h0, 48'(rf + 64'(b)), b[0]);
      chk(blk_done && blk_status == 2'b00, "R10 block ref advances", 64'(blk_status), 0);
      chk(xfer_done == (b == 3), "R11 end only on last", 64'(xfer_done), 64'(b == 3));
    end
    chk(fail_idx == 3 && xfer_status == 2'b00, "R11 final index", 64'(fail_idx), 3);
    do_cmd(0, 2'd2, 3'b100, 0, 0, 64'h0000_0001_0000_0000, 0, 0, rej, dnr);
    fill(9, 2);
    send_block(2, 0, 16'h0, 48'h0, 0);
    chk(blk_status == 2'b11, "R6 zero-extended mismatch", 64'(blk_status), 3);

    // R11 stop at a failing middle block
    do_cmd(0, 2'd1, 3'b111, 16'hABCD, 16'hFFFF, 64'h100, 64'h100, 4, rej, dnr);
    for (int b = 0; b < 3; b++) begin
      fill(b + 40, 4);
      send_block(4, ref_crc(0, 4), 16'hABCD, 48'h100 + 48'(b == 2 ? 7 : b), 0);
    end
    chk(blk_status == 2'b11 && xfer_done, "R11 fail stops", 64'(blk_status), 3);
    chk(fail_idx == 2, "R11 failing index", 64'(fail_idx), 2);
    chk(!s_ready, "R11 stream closed", 64'(s_ready), 0);

    // R10 type 3: tag fixed across blocks
    do_cmd(0, 2'd3, 3'b001, 0, 0, 64'h55, 0, 1, rej, dnr);
    fill(50, 3);
    send_block(3, ref_crc(0, 3), 16'h0, 48'h55, 0);
    send_block(3, ref_crc(0, 3), 16'h0, 48'h55, 0);
    chk(xfer_done && xfer_status == 2'b00 && fail_idx == 1, "R10 type3 two blocks", 64'(fail_idx), 1);

    // R12 fields changed mid-transfer are ignored; R13 stall
    do_cmd(0, 2'd2, 3'b110, 16'h4242, 16'hFFFF, 64'h9, 0, 1, rej, dnr);
    cmd_app_tag = 16'h0000; cmd_ref_lo = 32'h77; cmd_chk_guard = 1; cmd_start = 1;
    fill(60, 4);
    send_block(4, 64'h0, 16'h4242, 48'h9, 1);
    chk(blk_done && blk_status == 2'b00 && !xfer_done, "R12 latched fields", 64'(blk_status), 0);
    cmd_start = 0;
    repeat (5) @(negedge clk);
    send_block(4, 64'h0, 16'h4242, 48'hA, 0);
    chk(xfer_done && blk_status == 2'b00, "R13 stall then finish", 64'(blk_status), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule